// File: doc/BRIEF.md
# Expansion Bus Auto-Configuration Responder

This block lets a board with a byte-wide identification ROM take part in the power-up auto-configuration chain of a 24-bit expansion bus. While unconfigured, it claims every access to the configuration page (bus address bits 23:16 equal to a parameterised page number, 0xE8 by default). Reads in that page return bytes of the ROM. Host software reads the identification image there and then answers with a single byte write. That write either gives the board a base address or tells it to stay out of the map.

A base assignment places a 128 KB window of the same ROM at `base << 16`. The window may start on any 64 KB boundary. A shut-up write leaves the board silent. Either write raises `cfg_out` for one cycle, so the next board in the chain can start its own configuration. Word and long reads are put together big-endian from consecutive ROM bytes, one byte per clock, through a simple asynchronous ROM read port. A request is a one-cycle `bus_req` strobe. Every claimed access is answered with a one-cycle `bus_ack`. Unclaimed accesses get no answer.

Top module: `exp_cfg_resp`

## Requirements
- R1: After reset, `configured` is 0, `cfg_base` is 0, and `cfg_out` and `bus_ack` are low.
- R2: While unconfigured, an access whose address bits 23:16 equal the configuration page (0xE8) is claimed. A byte read returns ROM[addr[16:0]] in `bus_rdata[7:0]`, with the upper bits zero.
- R3: A word read returns {ROM[a], ROM[a+1]} in `bus_rdata[15:0]`, where a = addr[16:0]. The ROM index wraps modulo 128 KB.
- R4: A long read returns {ROM[a], ROM[a+1], ROM[a+2], ROM[a+3]}, with the lowest address in bits 31:24.
- R5: While unconfigured, a byte write to offset 0x48 (addr[15:0]) in the configuration page does three things: it sets `configured`, it loads `cfg_base` with `bus_wdata[7:0]` (the upper data bits are ignored), and it opens the ROM window.
- R6: While unconfigured, a byte write to offset 0x4C sets `configured` and opens no window. Afterwards no access anywhere is acknowledged.
- R7: `cfg_out` pulses for exactly one cycle, once per configuration. `configured` and `cfg_base` then hold until reset.
- R8: A word or long write to the configuration page, or a byte write to any other offset, is acknowledged and changes nothing.
- R9: Once configured, the responder no longer claims the configuration page.
- R10: A write inside the mapped window is acknowledged and has no effect: `cfg_base` is unchanged, no `cfg_out` pulse occurs, and reads return the same data.
- R11: With a window open, an access is claimed when (addr[23:16] − `cfg_base`) mod 256 is 0 or 1. Reads there return ROM[addr[16:0]].
- R12: An accepted write is acknowledged in the cycle after its accepting edge, in the same cycle as any `cfg_out` pulse. A read of k bytes is acknowledged k cycles after that. Size code 0 is byte, 1 is word, and 2 or 3 is long. A request that arrives during a read is ignored, and an unclaimed access is never acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req | input | 1 | One-cycle access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | 0 byte, 1 word, 2/3 long |
| bus_addr | input | 24 | Byte address |
| bus_wdata | input | 32 | Write data; only bits 7:0 are used |
| bus_rdata | output | 32 | Read data, valid with `bus_ack` |
| bus_ack | output | 1 | One-cycle acknowledge of a claimed access |
| cfg_out | output | 1 | One-cycle pulse to the next board in the chain |
| configured | output | 1 | Configuration finished |
| cfg_base | output | 8 | Assigned 64 KB page of the window |
| rom_addr | output | 17 | ROM byte index |
| rom_data | input | 8 | ROM byte at `rom_addr`, same cycle |

## Verification
The bench reads near the top of the 64 KB half of the ROM, so a word or long read crosses 0x0FFFF into 0x10000. A design that carried the index too narrowly, or put the bytes in the wrong order, returns the wrong data there.

It sends word and long writes to the base offset before configuring. A responder that decoded size loosely would configure early, which shows up as a pulse and a changed base. It repeats writes after configuration and writes into the window. A design that did not freeze its state would move the window or pulse `cfg_out` a second time.

Base 0xFF checks that the second 64 KB page wraps to page 0x00, which catches a decode that compares without wrap. A shut-up write followed by reads checks that the board stays silent, which catches a design that keeps answering in the configuration page.

// File: rtl/exp_cfg_pkg.sv
package exp_cfg_pkg;

    localparam int WIN_AW  = 17;   // 128 KB window, byte index
    localparam int PAGE_SH = 16;   // relocation unit is 64 KB

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2
    } xfer_size_e;

    function automatic logic [2:0] size_bytes(input logic [1:0] sz);
        case (sz)
            2'd0:    size_bytes = 3'd1;
            2'd1:    size_bytes = 3'd2;
            default: size_bytes = 3'd4;
        endcase
    endfunction

    typedef struct packed {
        logic              busy;
        logic [2:0]        left;
        logic [WIN_AW-1:0] ptr;
        logic [31:0]       shreg;
        logic              ack;
        logic [31:0]       rdata;
    } rd_st_t;

endpackage

// File: rtl/exp_cfg_decode.sv
module exp_cfg_decode #(
    parameter int          ADDR_W   = 24,
    parameter logic [7:0]  CFG_PAGE = 8'hE8
) (
    input  logic [ADDR_W-1:0]        addr,
    input  logic                     configured,
    input  logic                     mapped,
    input  logic [ADDR_W-17:0]       base,
    output logic                     in_cfg,
    output logic                     in_win
);
    localparam int PAGE_W = ADDR_W - exp_cfg_pkg::PAGE_SH;

    logic [PAGE_W-1:0] page;
    logic [PAGE_W-1:0] diff;

    always_comb begin
        page   = addr[ADDR_W-1:exp_cfg_pkg::PAGE_SH];
        diff   = page - base;
        in_cfg = !configured && (page == CFG_PAGE[PAGE_W-1:0]);
        in_win = mapped && (diff[PAGE_W-1:1] == '0);
    end
endmodule

// File: rtl/exp_cfg_ctrl.sv
module exp_cfg_ctrl #(
    parameter int          PAGE_W   = 8,
    parameter logic [15:0] OFF_BASE = 16'h0048,
    parameter logic [15:0] OFF_SHUT = 16'h004C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_acc,
    input  logic [1:0]        wr_size,
    input  logic [15:0]       wr_off,
    input  logic [7:0]        wr_byte,
    input  logic              in_cfg,
    output logic              configured,
    output logic              mapped,
    output logic [PAGE_W-1:0] base,
    output logic              cfg_out,
    output logic              wr_ack
);
    import exp_cfg_pkg::*;

    typedef struct packed {
        logic              configured;
        logic              mapped;
        logic [PAGE_W-1:0] base;
        logic              pulse;
        logic              wack;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        st_d.wack  = 1'b0;
        if (wr_acc) begin
            st_d.wack = 1'b1;
            if (in_cfg && !st_q.configured && wr_size == SZ_BYTE) begin
                if (wr_off == OFF_BASE) begin
                    st_d.base       = wr_byte[PAGE_W-1:0];
                    st_d.mapped     = 1'b1;
                    st_d.configured = 1'b1;
                    st_d.pulse      = 1'b1;
                end else if (wr_off == OFF_SHUT) begin
                    st_d.mapped     = 1'b0;
                    st_d.configured = 1'b1;
                    st_d.pulse      = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign configured = st_q.configured;
    assign mapped     = st_q.mapped;
    assign base       = st_q.base;
    assign cfg_out    = st_q.pulse;
    assign wr_ack     = st_q.wack;
endmodule

// File: rtl/exp_cfg_rdseq.sv
module exp_cfg_rdseq (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          rd_acc,
    input  logic [1:0]                    rd_size,
    input  logic [exp_cfg_pkg::WIN_AW-1:0] rd_idx,
    input  logic [7:0]                    rom_data,
    output logic [exp_cfg_pkg::WIN_AW-1:0] rom_addr,
    output logic                          busy,
    output logic                          rd_ack,
    output logic [31:0]                   rd_data
);
    import exp_cfg_pkg::*;

    rd_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.ack = 1'b0;
        if (st_q.busy) begin
            st_d.shreg = {st_q.shreg[23:0], rom_data};
            st_d.ptr   = st_q.ptr + 1'b1;
            st_d.left  = st_q.left - 1'b1;
            if (st_q.left == 3'd1) begin
                st_d.busy  = 1'b0;
                st_d.ack   = 1'b1;
                st_d.rdata = {st_q.shreg[23:0], rom_data};
            end
        end else if (rd_acc) begin
            st_d.busy  = 1'b1;
            st_d.left  = size_bytes(rd_size);
            st_d.ptr   = rd_idx;
            st_d.shreg = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rom_addr = st_q.ptr;
    assign busy     = st_q.busy;
    assign rd_ack   = st_q.ack;
    assign rd_data  = st_q.rdata;
endmodule

// File: rtl/exp_cfg_resp.sv
module exp_cfg_resp #(
    parameter int          ADDR_W   = 24,
    parameter logic [7:0]  CFG_PAGE = 8'hE8,
    parameter logic [15:0] OFF_BASE = 16'h0048,
    parameter logic [15:0] OFF_SHUT = 16'h004C
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_req,
    input  logic                     bus_we,
    input  logic [1:0]               bus_size,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [31:0]              bus_wdata,
    output logic [31:0]              bus_rdata,
    output logic                     bus_ack,
    output logic                     cfg_out,
    output logic                     configured,
    output logic [ADDR_W-17:0]       cfg_base,
    output logic [exp_cfg_pkg::WIN_AW-1:0] rom_addr,
    input  logic [7:0]               rom_data
);
    localparam int PAGE_W = ADDR_W - exp_cfg_pkg::PAGE_SH;

    logic in_cfg, in_win, win_mapped, busy, accept;
    logic wr_ack, rd_ack;
    logic [31:0] rd_data;

    exp_cfg_decode #(.ADDR_W(ADDR_W), .CFG_PAGE(CFG_PAGE)) u_dec (
        .addr       (bus_addr),
        .configured (configured),
        .mapped     (win_mapped),
        .base       (cfg_base),
        .in_cfg     (in_cfg),
        .in_win     (in_win)
    );

    assign accept = bus_req && !busy && (in_cfg || in_win);

    exp_cfg_ctrl #(.PAGE_W(PAGE_W), .OFF_BASE(OFF_BASE), .OFF_SHUT(OFF_SHUT)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_acc     (accept && bus_we),
        .wr_size    (bus_size),
        .wr_off     (bus_addr[15:0]),
        .wr_byte    (bus_wdata[7:0]),
        .in_cfg     (in_cfg),
        .configured (configured),
        .mapped     (win_mapped),
        .base       (cfg_base),
        .cfg_out    (cfg_out),
        .wr_ack     (wr_ack)
    );

    exp_cfg_rdseq u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_acc   (accept && !bus_we),
        .rd_size  (bus_size),
        .rd_idx   (bus_addr[exp_cfg_pkg::WIN_AW-1:0]),
        .rom_data (rom_data),
        .rom_addr (rom_addr),
        .busy     (busy),
        .rd_ack   (rd_ack),
        .rd_data  (rd_data)
    );

    assign bus_ack   = wr_ack | rd_ack;
    assign bus_rdata = rd_data;
endmodule

// File: rtl/exp_cfg_resp_chk.sv
module exp_cfg_resp_chk #(
    parameter int PAGE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_ack,
    input logic              cfg_out,
    input logic              configured,
    input logic              mapped,
    input logic [PAGE_W-1:0] base
);
    // R7
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_out |=> !cfg_out);

    // R5
    rise_with_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(configured) |-> cfg_out);

    // R7
    cfg_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        configured |=> configured);

    // R7
    base_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (configured && $past(configured)) |-> $stable(base));

    // R6
    shut_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (configured && !mapped) |-> (!bus_ack || cfg_out));
endmodule

bind exp_cfg_resp exp_cfg_resp_chk #(.PAGE_W(PAGE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_ack    (bus_ack),
    .cfg_out    (cfg_out),
    .configured (configured),
    .mapped     (win_mapped),
    .base       (cfg_base)
);

// File: tb/exp_cfg_resp_test.sv
module exp_cfg_resp_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_size = 2'd0;
    logic [23:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_ack, cfg_out, configured;
    logic [7:0]  cfg_base;
    logic [16:0] rom_addr;
    logic [7:0]  rom_data;

    int total = 0;
    int bad = 0;
    int pulses = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    function automatic logic [7:0] rom_fn(input logic [16:0] a);
        return a[7:0] ^ a[16:9];
    endfunction

    assign rom_data = rom_fn(rom_addr);

    exp_cfg_resp uut (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ack(bus_ack), .cfg_out(cfg_out),
        .configured(configured), .cfg_base(cfg_base),
        .rom_addr(rom_addr), .rom_data(rom_data)
    );

    always @(negedge clk) if (rst_n && cfg_out) pulses++;

    function automatic logic [31:0] exp_read(input logic [1:0] sz, input logic [23:0] addr);
        logic [16:0] a;
        a = addr[16:0];
        case (sz)
            2'd0:    return {24'h0, rom_fn(a)};
            2'd1:    return {16'h0, rom_fn(a), rom_fn(a + 17'd1)};
            default: return {rom_fn(a), rom_fn(a + 17'd1), rom_fn(a + 17'd2), rom_fn(a + 17'd3)};
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // issue one access; lat = negedge index (1..8) of first ack, 0 if none
    task automatic access(input logic we, input logic [1:0] sz, input logic [23:0] addr,
                          input logic [31:0] wd, output int lat, output logic [31:0] data);
        @(negedge clk);
        bus_req = 1'b1; bus_we = we; bus_size = sz; bus_addr = addr; bus_wdata = wd;
        @(posedge clk);
        #1 bus_req = 1'b0;
        lat = 0; data = '0;
        for (int k = 1; k <= 8; k++) begin
            @(negedge clk);
            if (bus_ack && lat == 0) begin
                lat = k; data = bus_rdata;
            end
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    typedef struct packed {
        logic        we;
        logic [1:0]  sz;
        logic [23:0] addr;
        logic [31:0] wd;
        logic [3:0]  lat;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 2'd0, 24'hE80000, 32'h0,        4'd2},  // R2 byte
        '{1'b0, 2'd0, 24'hE80003, 32'h0,        4'd2},  // R2 byte
        '{1'b0, 2'd1, 24'hE80010, 32'h0,        4'd3},  // R3 word
        '{1'b0, 2'd1, 24'hE8FFFF, 32'h0,        4'd3},  // R3 word crossing 0x10000
        '{1'b0, 2'd2, 24'hE80100, 32'h0,        4'd5},  // R4 long
        '{1'b0, 2'd3, 24'hE8FFFE, 32'h0,        4'd5},  // R4 long, size code 3
        '{1'b0, 2'd0, 24'hE90000, 32'h0,        4'd0},  // R12 unclaimed
        '{1'b1, 2'd1, 24'hE80048, 32'h0000_0033, 4'd1}, // R8 word write ignored
        '{1'b1, 2'd2, 24'hE8004C, 32'h0000_0044, 4'd1}, // R8 long write ignored
        '{1'b1, 2'd0, 24'hE80050, 32'h0000_0055, 4'd1}  // R8 other offset ignored
    };

    initial begin
        #400000;
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int lat;
        logic [31:0] d;

        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 configured", configured, 0);
        check("R1 base", cfg_base, 0);
        check("R1 ack/cfg_out", {bus_ack, cfg_out}, 0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            access(VECS[i].we, VECS[i].sz, VECS[i].addr, VECS[i].wd, lat, d);
            check("R12 latency", lat, VECS[i].lat);
            if (!VECS[i].we && VECS[i].lat != 0)
                check("R2/R3/R4 data", d, exp_read(VECS[i].sz, VECS[i].addr));
        end
        check("R8 still unconfigured", configured, 0);
        check("R8 no pulse", pulses, 0);

        // R12 request during read ignored
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_size = 2'd2; bus_addr = 24'hE80200;
        @(posedge clk);
        #1 bus_addr = 24'hE80048; bus_we = 1'b1; bus_size = 2'd0; bus_wdata = 32'h11;
        @(posedge clk);
        #1 bus_req = 1'b0;
        repeat (8) @(negedge clk);
        check("R12 req while busy ignored", configured, 0);

        // R5 base assignment, data masked to 8 bits
        access(1'b1, 2'd0, 24'hE80048, 32'hABCD_1241, lat, d);
        check("R12 write ack", lat, 1);
        check("R5 configured", configured, 1);
        check("R5 base", cfg_base, 8'h41);
        check("R7 one pulse", pulses, 1);

        // R11 window reads
        access(1'b0, 2'd0, 24'h410005, 32'h0, lat, d);
        check("R11 page base lat", lat, 2);
        check("R11 page base data", d, exp_read(2'd0, 24'h410005));
        access(1'b0, 2'd2, 24'h42FFFE, 32'h0, lat, d);
        check("R11 page base+1 lat", lat, 5);
        check("R11 page base+1 data", d, exp_read(2'd2, 24'h42FFFE));
        access(1'b0, 2'd0, 24'h430000, 32'h0, lat, d);
        check("R11 above window", lat, 0);
        access(1'b0, 2'd0, 24'h400000, 32'h0, lat, d);
        check("R11 below window", lat, 0);

        // R9 config page no longer decoded
        access(1'b0, 2'd0, 24'hE80000, 32'h0, lat, d);
        check("R9 cfg read", lat, 0);
        access(1'b1, 2'd0, 24'hE8004C, 32'h0, lat, d);
        check("R9 cfg write", lat, 0);
        check("R7 base held", cfg_base, 8'h41);

        // R10 window writes have no effect
        access(1'b1, 2'd0, 24'h410048, 32'h77, lat, d);
        check("R10 ack", lat, 1);
        check("R10 base", cfg_base, 8'h41);
        check("R10 no pulse", pulses, 1);
        access(1'b0, 2'd1, 24'h410048, 32'h0, lat, d);
        check("R10 read unchanged", d, exp_read(2'd1, 24'h410048));

        // R1 reset clears configuration
        do_reset();
        check("R1 reset configured", configured, 0);
        check("R1 reset base", cfg_base, 0);

        // R6 shut-up
        access(1'b1, 2'd0, 24'hE8004C, 32'h99, lat, d);
        check("R6 ack", lat, 1);
        check("R6 configured", configured, 1);
        check("R7 pulse", pulses, 2);
        access(1'b0, 2'd0, 24'hE80000, 32'h0, lat, d);
        check("R6 cfg silent", lat, 0);
        access(1'b0, 2'd0, 24'h000010, 32'h0, lat, d);
        check("R6 low page silent", lat, 0);

        // R11 window wrap with base 0xFF
        do_reset();
        access(1'b1, 2'd0, 24'hE80048, 32'h0000_00FF, lat, d);
        check("R5 base FF", cfg_base, 8'hFF);
        access(1'b0, 2'd0, 24'h000010, 32'h0, lat, d);
        check("R11 wrap lat", lat, 2);
        check("R11 wrap data", d, exp_read(2'd0, 24'h000010));
        access(1'b0, 2'd1, 24'hFF0020, 32'h0, lat, d);
        check("R11 FF page data", d, exp_read(2'd1, 24'hFF0020));
        access(1'b0, 2'd0, 24'h010000, 32'h0, lat, d);
        check("R11 wrap edge", lat, 0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule